// File: doc/BRIEF.md
# First-Error Capture Logging Unit

This unit watches a small set of error detectors and keeps a record of which fault arrived first. The first event, or every source that fires in the same cycle as that event, sets bits in a first-error status word. Any error that shows up while that word still holds something is recorded in a separate next-error word instead, so software can tell the root cause from the fallout. When the first recorded event is an uncorrectable memory error, the unit also latches the check bits of the failing word and the transaction context (transaction ID and data chunk index) that came with it.

Software reads the four registers through a byte-addressed, single-cycle register port and acknowledges errors by writing ones. A write of ones to either status word clears those bits in both words. If a hardware error lands in the same cycle as such a clear, the unit raises a collision flag in the first-error word. The flag warns that capture data may not match the bits that are set.

Top module: `err_first_log`

## Requirements
- R1: After reset, the first-error word (address 0x00), the next-error word (0x04), the check-bit capture (0x08) and the transaction capture (0x0C) all read as zero.
- R2: Error sources map to status bits as follows: err_i[0] uncorrectable memory error is bit 0, err_i[1] length-field mismatch is bit 27, err_i[2] write-data protocol error is bit 28, err_i[3] ready/busy handshake error is bit 29, err_i[4] private-bus receive length error is bit 30. A pulse that arrives while bits 30:0 of the first-error word are all zero sets its bit there, and the bit reads back in the cycle after the clock edge that sampled it.
- R3: A pulse that arrives while any of bits 30:0 of the first-error word is set leaves the first-error word unchanged and sets the matching bit of the next-error word.
- R4: Several sources firing in the same cycle while the first-error word is empty are all recorded in the first-error word.
- R5: A register write of a one to bit n at address 0x00 or 0x04 clears bit n in both status words. Bits written as zero are left as they are.
- R6: Bit 31 of the first-error word is set when a write with nonzero data to 0x00 or 0x04 and at least one error pulse occur in the same cycle. The new error's own bit is set even when that same bit is being cleared.
- R7: Bit 31 is never set while bits 30:0 of the first-error word are all zero. Writing a one to bit 31 clears it.
- R8: The check-bit and transaction captures load only in a cycle where err_i[0] sets bit 0 of an empty first-error word and no collision (R6) occurs. In every other cycle they hold their value.
- R9: The transaction capture reads with the transaction ID in bits 5:0, the chunk index in bits 8:6, and zero in bits 15:9 and above.
- R10: Writes to 0x08 and 0x0C, and writes to status bits 26:1, change nothing. Reads of any other address return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_i | input | 5 | Error pulses from the detectors, one per source |
| ded_ecc_i | input | 8 | Check bits belonging to the uncorrectable memory error |
| ded_id_i | input | 6 | Transaction ID belonging to the uncorrectable memory error |
| ded_chunk_i | input | 3 | Data chunk index belonging to the uncorrectable memory error |
| reg_addr_i | input | 8 | Register byte address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data (ones clear status bits) |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |

## Verification
Each error pulse, clear write and capture load is driven just after a falling edge and takes effect at the next rising edge. It is therefore due on the read port one edge after it is presented. Reads are combinational from the registers, so the bench applies an address with the write strobe low and compares a moment later, between edges. Every check follows a whole clock cycle after its stimulus. Collision cases put the clear write and the error in the same driven cycle, and the check reads both status words and both captures afterwards.

// File: rtl/errlog_pkg.sv
package errlog_pkg;

    localparam int STAT_W   = 32;
    localparam int SRC_N    = 5;
    localparam int ECC_W    = 8;
    localparam int ID_W     = 6;
    localparam int CHUNK_W  = 3;
    localparam int TX_W     = 16;
    localparam int COLL_BIT = 31;
    localparam int DED_BIT  = 0;

    localparam logic [7:0] ADDR_FIRST = 8'h00;
    localparam logic [7:0] ADDR_NEXT  = 8'h04;
    localparam logic [7:0] ADDR_ECC   = 8'h08;
    localparam logic [7:0] ADDR_TX    = 8'h0C;

    // status bit position for each source index
    function automatic int src_pos(input int idx);
        case (idx)
            0:       return DED_BIT;
            1:       return 27;
            2:       return 28;
            3:       return 29;
            default: return 30;
        endcase
    endfunction

    typedef struct packed {
        logic [STAT_W-1:0] first;
        logic [STAT_W-1:0] next;
    } status_t;

    typedef struct packed {
        logic [ECC_W-1:0] ecc;
        logic [TX_W-1:0]  tx;
    } capture_t;

endpackage

// File: rtl/errlog_src_map.sv
module errlog_src_map
    import errlog_pkg::*;
(
    input  logic [SRC_N-1:0]  err_i,
    output logic [STAT_W-1:0] bits_o
);
    logic [SRC_N-1:0][STAT_W-1:0] part;

    for (genvar g = 0; g < SRC_N; g++) begin : g_src
        localparam int POS = src_pos(g);
        assign part[g] = {{(STAT_W-1){1'b0}}, err_i[g]} << POS;
    end

    always_comb begin
        bits_o = '0;
        for (int i = 0; i < SRC_N; i++) begin
            bits_o = bits_o | part[i];
        end
    end
endmodule

// File: rtl/errlog_status.sv
module errlog_status
    import errlog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] src_bits,
    input  logic [STAT_W-1:0] clr_mask,
    input  logic              clr_act,
    output logic [STAT_W-1:0] first_q,
    output logic [STAT_W-1:0] next_q,
    output logic              cap_load
);
    localparam int LOW_W = STAT_W - 1;

    status_t st_d, st_q;
    logic    first_empty;
    logic    collide;
    logic [LOW_W-1:0] first_low_d;

    always_comb begin
        first_empty = (st_q.first[LOW_W-1:0] == '0);
        collide     = clr_act && (src_bits != '0);
        first_low_d = (st_q.first[LOW_W-1:0] & ~clr_mask[LOW_W-1:0])
                    | (first_empty ? src_bits[LOW_W-1:0] : '0);

        st_d = st_q;
        st_d.first[LOW_W-1:0] = first_low_d;
        st_d.first[COLL_BIT]  = ((st_q.first[COLL_BIT] & ~clr_mask[COLL_BIT]) | collide)
                              & (first_low_d != '0);
        st_d.next[LOW_W-1:0]  = (st_q.next[LOW_W-1:0] & ~clr_mask[LOW_W-1:0])
                              | (first_empty ? '0 : src_bits[LOW_W-1:0]);
        st_d.next[COLL_BIT]   = 1'b0;

        cap_load = first_empty && src_bits[DED_BIT] && !collide;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign first_q = st_q.first;
    assign next_q  = st_q.next;
endmodule

// File: rtl/errlog_capture.sv
module errlog_capture
    import errlog_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_load,
    input  logic [ECC_W-1:0]   ecc_in,
    input  logic [ID_W-1:0]    id_in,
    input  logic [CHUNK_W-1:0] chunk_in,
    output logic [ECC_W-1:0]   ecc_q,
    output logic [TX_W-1:0]    tx_q
);
    localparam int PAD_W = TX_W - ID_W - CHUNK_W;

    capture_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (cap_load) begin
            cap_d.ecc = ecc_in;
            cap_d.tx  = {{PAD_W{1'b0}}, chunk_in, id_in};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign ecc_q = cap_q.ecc;
    assign tx_q  = cap_q.tx;
endmodule

// File: rtl/errlog_regport.sv
module errlog_regport
    import errlog_pkg::*;
#(
    parameter int ADDR_W = 8
)(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [STAT_W-1:0] wdata,
    input  logic [STAT_W-1:0] first_q,
    input  logic [STAT_W-1:0] next_q,
    input  logic [ECC_W-1:0]  ecc_q,
    input  logic [TX_W-1:0]   tx_q,
    output logic [STAT_W-1:0] clr_mask,
    output logic              clr_act,
    output logic [STAT_W-1:0] rdata
);
    logic stat_sel;

    always_comb begin
        stat_sel = (addr == ADDR_W'(ADDR_FIRST)) || (addr == ADDR_W'(ADDR_NEXT));
        clr_mask = (wr && stat_sel) ? wdata : '0;
        clr_act  = (clr_mask != '0);

        if (addr == ADDR_W'(ADDR_FIRST))      rdata = first_q;
        else if (addr == ADDR_W'(ADDR_NEXT))  rdata = next_q;
        else if (addr == ADDR_W'(ADDR_ECC))   rdata = STAT_W'(ecc_q);
        else if (addr == ADDR_W'(ADDR_TX))    rdata = STAT_W'(tx_q);
        else                                  rdata = '0;
    end
endmodule

// File: rtl/err_first_log.sv
module err_first_log
    import errlog_pkg::*;
#(
    parameter int ADDR_W = 8
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SRC_N-1:0]   err_i,
    input  logic [ECC_W-1:0]   ded_ecc_i,
    input  logic [ID_W-1:0]    ded_id_i,
    input  logic [CHUNK_W-1:0] ded_chunk_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic               reg_wr_i,
    input  logic [STAT_W-1:0]  reg_wdata_i,
    output logic [STAT_W-1:0]  reg_rdata_o
);
    localparam int LOW_W = STAT_W - 1;

    logic [STAT_W-1:0] src_bits;
    logic [STAT_W-1:0] clr_mask;
    logic              clr_act;
    logic [STAT_W-1:0] first_q;
    logic [STAT_W-1:0] next_q;
    logic              cap_load;
    logic [ECC_W-1:0]  ecc_q;
    logic [TX_W-1:0]   tx_q;

    errlog_src_map u_map (
        .err_i  (err_i),
        .bits_o (src_bits)
    );

    errlog_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_bits (src_bits),
        .clr_mask (clr_mask),
        .clr_act  (clr_act),
        .first_q  (first_q),
        .next_q   (next_q),
        .cap_load (cap_load)
    );

    errlog_capture u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_load (cap_load),
        .ecc_in   (ded_ecc_i),
        .id_in    (ded_id_i),
        .chunk_in (ded_chunk_i),
        .ecc_q    (ecc_q),
        .tx_q     (tx_q)
    );

    errlog_regport #(.ADDR_W(ADDR_W)) u_port (
        .addr     (reg_addr_i),
        .wr       (reg_wr_i),
        .wdata    (reg_wdata_i),
        .first_q  (first_q),
        .next_q   (next_q),
        .ecc_q    (ecc_q),
        .tx_q     (tx_q),
        .clr_mask (clr_mask),
        .clr_act  (clr_act),
        .rdata    (reg_rdata_o)
    );

    // R2 R4
    first_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (first_q[LOW_W-1:0] == '0 && err_i != '0)
        |=> ((first_q & $past(src_bits)) == $past(src_bits)));

    // R3
    next_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (first_q[LOW_W-1:0] != '0 && err_i != '0 && !clr_act)
        |=> (first_q == $past(first_q) && (next_q & $past(src_bits)) == $past(src_bits)));

    // R5
    clear_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_act && err_i == '0)
        |=> ((first_q & $past(clr_mask)) == '0 && (next_q & $past(clr_mask)) == '0));

    // R6
    collide_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_act && err_i != '0 && first_q[LOW_W-1:0] == '0) |=> first_q[COLL_BIT]);

    // R7
    flag_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        first_q[COLL_BIT] |-> (first_q[LOW_W-1:0] != '0));

    // R8
    capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(first_q[LOW_W-1:0] == '0 && err_i[0] && !clr_act)
        |=> ($stable(ecc_q) && $stable(tx_q)));
endmodule

// File: tb/err_first_log_test.sv
module err_first_log_test;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  err_i = '0;
    logic [7:0]  ded_ecc_i = '0;
    logic [5:0]  ded_id_i = '0;
    logic [2:0]  ded_chunk_i = '0;
    logic [7:0]  reg_addr_i = '0;
    logic        reg_wr_i = 1'b0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    err_first_log uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .err_i       (err_i),
        .ded_ecc_i   (ded_ecc_i),
        .ded_id_i    (ded_id_i),
        .ded_chunk_i (ded_chunk_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wr_i    (reg_wr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // one clock cycle of stimulus, entered and left at a falling edge
    task automatic drive(input logic [4:0] e, input logic wr, input logic [7:0] a,
                         input logic [31:0] d, input logic [7:0] ecc,
                         input logic [5:0] id, input logic [2:0] ch);
        err_i = e; reg_wr_i = wr; reg_addr_i = a; reg_wdata_i = d;
        ded_ecc_i = ecc; ded_id_i = id; ded_chunk_i = ch;
        @(posedge clk);
        @(negedge clk);
        err_i = '0; reg_wr_i = 1'b0; reg_wdata_i = '0;
    endtask

    task automatic pulse(input logic [4:0] e);
        drive(e, 1'b0, 8'h00, 32'h0, 8'h00, 6'h0, 3'h0);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        drive(5'b0, 1'b1, a, d, 8'h00, 6'h0, 3'h0);
    endtask

    task automatic expect_reg(input logic [7:0] a, input logic [31:0] exp, input string req);
        reg_addr_i = a;
        #1;
        checks++;
        if (reg_rdata_o !== exp) begin
            failures++;
            $display("FAIL %s addr=%02h actual=%08h expected=%08h", req, a, reg_rdata_o, exp);
        end
    endtask

    task automatic clear_all();
        wr(8'h00, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        expect_reg(8'h00, 32'h0, "R1");
        expect_reg(8'h04, 32'h0, "R1");
        expect_reg(8'h08, 32'h0, "R1");
        expect_reg(8'h0C, 32'h0, "R1");
    endtask

    task automatic t_first_next_clear();
        pulse(5'b00100);                        // write-data error, bit 28
        expect_reg(8'h00, 32'h1000_0000, "R2");
        expect_reg(8'h04, 32'h0, "R2");
        pulse(5'b10000);                        // receive length error, bit 30
        expect_reg(8'h00, 32'h1000_0000, "R3");
        expect_reg(8'h04, 32'h4000_0000, "R3");
        wr(8'h00, 32'h0);                       // zeros change nothing
        expect_reg(8'h00, 32'h1000_0000, "R5");
        wr(8'h00, 32'h07FF_FFFE);               // reserved bits only
        expect_reg(8'h00, 32'h1000_0000, "R10");
        expect_reg(8'h04, 32'h4000_0000, "R10");
        wr(8'h00, 32'h1000_0000);
        expect_reg(8'h00, 32'h0, "R5");
        expect_reg(8'h04, 32'h4000_0000, "R5");
        wr(8'h04, 32'h4000_0000);
        expect_reg(8'h04, 32'h0, "R5");
    endtask

    task automatic t_simultaneous();
        pulse(5'b01010);                        // bits 27 and 29
        expect_reg(8'h00, 32'h2800_0000, "R4");
        expect_reg(8'h04, 32'h0, "R4");
        expect_reg(8'h08, 32'h0, "R8");
        clear_all();
        expect_reg(8'h00, 32'h0, "R5");
    endtask

    task automatic t_capture();
        drive(5'b00001, 1'b0, 8'h00, 32'h0, 8'hA5, 6'h2A, 3'h5);
        expect_reg(8'h00, 32'h0000_0001, "R2");
        expect_reg(8'h08, 32'h0000_00A5, "R8");
        expect_reg(8'h0C, 32'h0000_016A, "R9");
        drive(5'b00001, 1'b0, 8'h00, 32'h0, 8'h5A, 6'h11, 3'h2);
        expect_reg(8'h04, 32'h0000_0001, "R3");
        expect_reg(8'h08, 32'h0000_00A5, "R8");
        expect_reg(8'h0C, 32'h0000_016A, "R8");
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h0C, 32'hFFFF_FFFF);
        expect_reg(8'h08, 32'h0000_00A5, "R10");
        expect_reg(8'h0C, 32'h0000_016A, "R10");
        expect_reg(8'h20, 32'h0, "R10");
        clear_all();
        expect_reg(8'h04, 32'h0, "R5");
    endtask

    task automatic t_collision();
        pulse(5'b00100);                        // first = bit 28
        drive(5'b01000, 1'b1, 8'h00, 32'h1000_0000, 8'h00, 6'h0, 3'h0);
        expect_reg(8'h00, 32'h0, "R7");         // flag suppressed, nothing else set
        expect_reg(8'h04, 32'h2000_0000, "R3");
        pulse(5'b00100);
        drive(5'b00010, 1'b1, 8'h04, 32'h2000_0000, 8'h00, 6'h0, 3'h0);
        expect_reg(8'h00, 32'h9000_0000, "R6");
        expect_reg(8'h04, 32'h0800_0000, "R6");
        wr(8'h00, 32'h8000_0000);
        expect_reg(8'h00, 32'h1000_0000, "R7");
        clear_all();
        // same bit cleared and raised together: new error wins
        pulse(5'b00100);
        drive(5'b00100, 1'b1, 8'h00, 32'h1000_0000, 8'h00, 6'h0, 3'h0);
        expect_reg(8'h04, 32'h1000_0000, "R6");
        clear_all();
        // collision on an empty first word with an uncorrectable error
        drive(5'b00001, 1'b1, 8'h04, 32'h0000_0001, 8'h3C, 6'h07, 3'h1);
        expect_reg(8'h00, 32'h8000_0001, "R6");
        expect_reg(8'h08, 32'h0000_00A5, "R8");
        expect_reg(8'h0C, 32'h0000_016A, "R8");
        clear_all();
        expect_reg(8'h00, 32'h0, "R7");
    endtask

    task automatic t_layout();
        drive(5'b00001, 1'b0, 8'h00, 32'h0, 8'h11, 6'h3F, 3'h7);
        expect_reg(8'h0C, 32'h0000_01FF, "R9");
        expect_reg(8'h08, 32'h0000_0011, "R8");
        clear_all();
        drive(5'b00001, 1'b0, 8'h00, 32'h0, 8'h22, 6'h00, 3'h4);
        expect_reg(8'h0C, 32'h0000_0100, "R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_next_clear();
        t_simultaneous();
        t_capture();
        t_collision();
        t_layout();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule